// File: doc/BRIEF.md
# Midpath Delay Detection Clock Stretcher

This block produces the capture enable for one destination register stage. It counts ticks of a fast reference clock to build a base period of `PERIOD` ticks. The first half of each period is the high phase and the second half is the low phase. On the last tick of the high phase it samples a net that sits about halfway along a critical path. A healthy transition on that net has already settled by then. During the low phase it compares the sample with the live net value on every tick up to the one before the nominal capture tick.

A mismatch means the transition arrived late. When stretching is enabled, the block lengthens only the current period by a margin of about ten percent. The capture pulse therefore comes later and the destination register gets extra settling time in the same cycle. The decision is made per cycle, with no voltage or frequency loop involved.

A period that follows a stretched period is never stretched itself, so downstream stages do not lose time to two extensions in a row. Mismatches are always reported on an error flag, even when stretching is disabled or blocked. A saturating counter records how many periods were stretched.

Top module: `midpath_stretch_clkgen`

## Requirements
- R1: While `rst_ni` is low, the tick position is 0 and `cap_en_o`, `stretch_o` and `late_err_o` are low. `stretch_cnt_o` is 0.
- R2: With no late transition, `cap_en_o` is high for exactly one tick, at tick position `PERIOD-1`. The period then restarts at position 0, so pulses are `PERIOD` ticks apart.
- R3: The midpoint net is sampled on the tick at position `PERIOD/2-1`, the last tick of the high phase. A change of the net at or before that position is not a late transition.
- R4: A difference between the live net and the sample, seen on any tick at positions `PERIOD/2` to `PERIOD-2`, raises `late_err_o` from the next tick. The flag stays high until the period's capture tick and is low at position 0 of the next period.
- R5: With `stretch_en_i` high and the period not blocked, a late transition moves the capture pulse to position `PERIOD+M-1`, where M = max(1, ceil(PERIOD/10)). For the default `PERIOD` of 20 this is position 21.
- R6: `stretch_o` is high from the tick after the late transition is detected through the capture tick of that stretched period. It is low at position 0 of the next period.
- R7: The period right after a stretched period always has nominal length, even with a late transition. Its error flag is still raised. The period after that may stretch again.
- R8: With `stretch_en_i` low, periods have nominal length and the counter does not change, but `late_err_o` still reports late transitions.
- R9: `stretch_cnt_o` rises by one for each stretched period and holds at 2^CNT_W-1 once it gets there.
- R10: A change of the net at position `PERIOD-1` or later in a period is not a late transition for that period. It raises no error flag and causes no stretch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference tick clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mid_i | input | 1 | Monitored midpoint net of the critical path |
| stretch_en_i | input | 1 | Allows late transitions to lengthen the period |
| cap_en_o | output | 1 | One-tick capture enable for the destination stage |
| stretch_o | output | 1 | Current period has been stretched |
| late_err_o | output | 1 | Late transition seen in the current period |
| stretch_cnt_o | output | CNT_W | Saturating count of stretched periods |

## Verification
The bench sweeps the net's transition across every tick position of the period, with stretching both enabled and disabled. This includes the boundaries at `PERIOD/2-1` and `PERIOD/2`, and at `PERIOD-2` and `PERIOD-1`. If the sample point were one tick off, a healthy transition would be flagged, or a late one would be missed. A detection window that ran into the capture tick would stretch after the pulse had already gone out. Runs of back-to-back late periods check that a second stretch in a row is refused while the error is still reported. A long run of stretched periods pushes the counter to saturation, where wrapping to zero would show up at once.

// File: rtl/mps_pkg.sv
package mps_pkg;

    // Position of the current tick inside one capture period
    typedef enum logic [1:0] {
        PH_HIGH        = 2'd0,  // base clock high, sampling phase
        PH_WATCH       = 2'd1,  // low phase, late transitions detected
        PH_NOMINAL_END = 2'd2,  // nominal capture tick
        PH_EXTEND      = 2'd3   // extra ticks of a stretched period
    } phase_e;

    // Stretch margin: a tenth of the period, rounded up, at least one tick
    function automatic int margin_ticks(input int period);
        int m;
        m = (period + 9) / 10;
        if (m < 1) m = 1;
        return m;
    endfunction

endpackage

// File: rtl/mps_phase_timer.sv
module mps_phase_timer
    import mps_pkg::*;
#(
    parameter int PERIOD = 20,
    parameter int MARGIN = 2
) (
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   stretch_i,
    output phase_e phase_o,
    output logic   sample_pt_o,
    output logic   period_end_o
);

    localparam int LONG = PERIOD + MARGIN;
    localparam int HALF = PERIOD / 2;
    localparam int TW   = $clog2(LONG);
    localparam logic [TW-1:0] LAST_NOM  = TW'(PERIOD - 1);
    localparam logic [TW-1:0] LAST_LONG = TW'(LONG - 1);
    localparam logic [TW-1:0] SAMPLE_AT = TW'(HALF - 1);
    localparam logic [TW-1:0] WATCH_AT  = TW'(HALF);

    typedef struct packed {
        logic [TW-1:0] tick;
    } timer_t;

    timer_t st_d, st_q;
    logic   end_now;

    always_comb begin
        st_d    = st_q;
        end_now = (st_q.tick == (stretch_i ? LAST_LONG : LAST_NOM));
        if (end_now) st_d.tick = '0;
        else         st_d.tick = st_q.tick + 1'b1;

        if (st_q.tick < WATCH_AT)       phase_o = PH_HIGH;
        else if (st_q.tick < LAST_NOM)  phase_o = PH_WATCH;
        else if (st_q.tick == LAST_NOM) phase_o = PH_NOMINAL_END;
        else                            phase_o = PH_EXTEND;

        sample_pt_o  = (st_q.tick == SAMPLE_AT);
        period_end_o = end_now;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // Capture pulse lasts one tick and the period restarts at zero
    assert_pulse_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_end_o |=> !period_end_o);
    assert_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_end_o |=> (st_q.tick == '0));
    // A period never runs past the stretched length
    assert_tick_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.tick <= LAST_LONG);

endmodule

// File: rtl/mps_mid_monitor.sv
module mps_mid_monitor
    import mps_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   mid_i,
    input  phase_e phase_i,
    input  logic   sample_pt_i,
    output logic   late_o
);

    typedef struct packed {
        logic sample;
    } mon_t;

    mon_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample_pt_i) st_d.sample = mid_i;
        late_o = (phase_i == PH_WATCH) && (mid_i != st_q.sample);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // The held sample changes only at the end of the high phase
    assert_sample_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sample_pt_i |=> $stable(st_q.sample));

endmodule

// File: rtl/mps_stretch_ctrl.sv
module mps_stretch_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             late_i,
    input  logic             period_end_i,
    output logic             stretch_o,
    output logic             err_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             stretch;
        logic             guard;
        logic             err;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (period_end_i) begin
            st_d.stretch = 1'b0;
            st_d.err     = 1'b0;
            st_d.guard   = st_q.stretch;
        end else if (late_i) begin
            st_d.err = 1'b1;
            if (en_i && !st_q.guard) st_d.stretch = 1'b1;
        end
        if (st_d.stretch && !st_q.stretch && (st_q.cnt != CNT_MAX))
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stretch_o = st_q.stretch;
    assign err_o     = st_q.err;
    assign cnt_o     = st_q.cnt;

    // A period following a stretched one is never stretched
    assert_no_double_stretch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.guard |-> !st_q.stretch);
    // Stretch starts only while enabled
    assert_enable_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.stretch) |-> $past(en_i));
    // Flags are cleared at the period start
    assert_flags_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_end_i |=> (!st_q.err && !st_q.stretch));
    // Counter saturates and never moves by more than one
    assert_cnt_sat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt == CNT_MAX) |=> (st_q.cnt == CNT_MAX));
    assert_cnt_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt != CNT_MAX) |=> ((st_q.cnt == $past(st_q.cnt)) ||
                                   (st_q.cnt == $past(st_q.cnt) + 1'b1)));

endmodule

// File: rtl/midpath_stretch_clkgen.sv
module midpath_stretch_clkgen
    import mps_pkg::*;
#(
    parameter int PERIOD = 20,
    parameter int CNT_W  = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mid_i,
    input  logic             stretch_en_i,
    output logic             cap_en_o,
    output logic             stretch_o,
    output logic             late_err_o,
    output logic [CNT_W-1:0] stretch_cnt_o
);

    localparam int MARGIN = margin_ticks(PERIOD);

    phase_e phase;
    logic   sample_pt;
    logic   period_end;
    logic   late;
    logic   stretch;

    mps_phase_timer #(
        .PERIOD (PERIOD),
        .MARGIN (MARGIN)
    ) u_timer (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .stretch_i    (stretch),
        .phase_o      (phase),
        .sample_pt_o  (sample_pt),
        .period_end_o (period_end)
    );

    mps_mid_monitor u_monitor (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mid_i       (mid_i),
        .phase_i     (phase),
        .sample_pt_i (sample_pt),
        .late_o      (late)
    );

    mps_stretch_ctrl #(
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .en_i         (stretch_en_i),
        .late_i       (late),
        .period_end_i (period_end),
        .stretch_o    (stretch),
        .err_o        (late_err_o),
        .cnt_o        (stretch_cnt_o)
    );

    assign cap_en_o  = period_end;
    assign stretch_o = stretch;

    // Capture pulse is never on a low-phase watch tick
    assert_no_early_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase == PH_WATCH) |-> !cap_en_o);

endmodule

// File: tb/midpath_stretch_clkgen_test.sv
`timescale 1ns/1ps
module midpath_stretch_clkgen_test;

    localparam int PERIOD = 20;
    localparam int CNT_W  = 3;
    localparam int HALF   = PERIOD / 2;
    localparam int MARG   = ((PERIOD + 9) / 10 < 1) ? 1 : (PERIOD + 9) / 10;
    localparam int LONG   = PERIOD + MARG;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_ni;
    logic             mid;
    logic             en;
    logic             cap_en;
    logic             stretch;
    logic             late_err;
    logic [CNT_W-1:0] cnt;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    bit  exp_guard = 1'b0;
    int  exp_cnt   = 0;

    always #4 clk = ~clk;

    midpath_stretch_clkgen #(.PERIOD(PERIOD), .CNT_W(CNT_W)) uut (
        .clk_i         (clk),
        .rst_ni        (rst_ni),
        .mid_i         (mid),
        .stretch_en_i  (en),
        .cap_en_o      (cap_en),
        .stretch_o     (stretch),
        .late_err_o    (late_err),
        .stretch_cnt_o (cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One period starting at a falling edge where the design is at tick 0.
    // tg < 0 means the net stays quiet.
    task automatic run_period(input int tg, input bit en_v);
        bit    det;
        bit    str;
        int    len;
        string cap_tag;
        string err_tag;
        en  = en_v;
        det = (tg >= HALF) && (tg <= PERIOD - 2);
        str = det && en_v && !exp_guard;
        len = str ? LONG : PERIOD;
        if (str)                      cap_tag = "R5 capture";
        else if (det && exp_guard)    cap_tag = "R7 capture";
        else if (det)                 cap_tag = "R8 capture";
        else if (tg >= 0 && tg < HALF) cap_tag = "R3 capture";
        else if (tg >= PERIOD - 1)    cap_tag = "R10 capture";
        else                          cap_tag = "R2 capture";
        if (det)                      err_tag = en_v ? "R4 error" : "R8 error";
        else if (tg >= 0 && tg < HALF) err_tag = "R3 error";
        else if (tg >= PERIOD - 1)    err_tag = "R10 error";
        else                          err_tag = "R4 error";
        for (int t = 0; t < len; t++) begin
            if (t == tg) mid = ~mid;
            chk(cap_tag, int'(cap_en), int'(t == len - 1));
            chk(err_tag, int'(late_err), int'(det && (t > tg)));
            chk("R6 stretch", int'(stretch), int'(str && (t > tg)));
            @(negedge clk);
        end
        chk("R6 stretch at start", int'(stretch), 0);
        chk("R4 error at start", int'(late_err), 0);
        exp_guard = str;
        if (str && exp_cnt < CMAX) exp_cnt++;
        chk("R9 counter", int'(cnt), exp_cnt);
    endtask

    initial begin
        rst_ni = 1'b0;
        mid    = 1'b0;
        en     = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 cap", int'(cap_en), 0);
        chk("R1 stretch", int'(stretch), 0);
        chk("R1 error", int'(late_err), 0);
        chk("R1 counter", int'(cnt), 0);
        rst_ni = 1'b1;

        // Sweep every toggle position, with a quiet period in between
        for (int e = 0; e < 2; e++) begin
            for (int tg = -1; tg < LONG; tg++) begin
                run_period(tg, bit'(e));
                run_period(-1, bit'(e));
            end
        end

        // Back-to-back late periods, stretch enabled (R7)
        for (int tg = HALF; tg <= PERIOD - 2; tg++) begin
            run_period(tg, 1'b1);
        end
        run_period(HALF + 2, 1'b1);
        run_period(HALF + 2, 1'b1);
        run_period(HALF + 2, 1'b1);

        // Disabled run with late transitions (R8)
        run_period(HALF + 1, 1'b0);
        run_period(PERIOD - 2, 1'b0);

        // Counter saturation (R9)
        for (int i = 0; i < 2 * CMAX + 6; i++) begin
            run_period(HALF, 1'b1);
        end
        chk("R9 saturated", int'(cnt), CMAX);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule